// File: doc/BRIEF.md
# Differential Clock Output Gate

This block sits between a synthesized clock and four differential output pairs. For each pair it decides, cycle by cycle, whether the pair toggles, is parked at a fixed driven level, or is released to high impedance. The decision depends on a per-pair enable, a per-pair stop-permission bit, a single global stop request pin and a global park-mode bit. The configuration bits come from registers outside this block. Those registers reset with every pair enabled, no pair stoppable and the driven park mode selected.

The stop request pin is active low and asynchronous to the clock. It and all configuration bits pass through a synchronizer on the falling clock edge. A registered gate stage, also updated on the falling edge, then opens or closes each pair's gate. Because the gate only moves while the clock is low, a pair always starts and stops on whole pulses. While the block is in reset every pair is released to high impedance. A pair comes out of that state only when its enable has crossed the synchronizer.

Top module: `diffclk_gate`

## Requirements
- R1: While `rst_n` is low, and until the enables have crossed the synchronizer after release, every `dif_oe` bit is 0, every `dif_t` bit is 0 and every `dif_c` bit is 1.
- R2: While `stop_pin_n` is 0, a pair whose `stop_able` bit is 0 keeps toggling with the clock and keeps `dif_oe` at 1.
- R3: While `stop_pin_n` is 0 and `park_hiz` is 0, a pair whose `stop_able` bit is 1 has `dif_oe` at 1, `dif_t` held at 0 and `dif_c` held at 1.
- R4: While `stop_pin_n` is 0 and `park_hiz` is 1, a pair whose `stop_able` bit is 1 has `dif_oe` at 0.
- R5: A pair whose `out_en` bit is 0 has `dif_oe` at 0 and `dif_t` at 0, whatever the state of the stop pin and park mode.
- R6: A change to any control input held through the high phase of clock cycle j appears on the outputs from the high phase that starts at the third rising edge after cycle j's rising edge. The earlier high phases still show the previous setting.
- R7: During every low phase of the clock `dif_t` is 0 and `dif_c` is 1. A pair's gate opens or closes only while the clock is low, so no partial high pulse is produced.
- R8: A running pair's `dif_t` is high in each high phase of the clock. In every phase `dif_c` is the exact inverse of `dif_t`, and both wires of a pair share one drive-enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pll_clk | input | 1 | Synthesized clock feeding all pairs |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_pin_n | input | 1 | Asynchronous global stop request, active low |
| out_en | input | NUM_OUT | Per-pair enable, 0 releases the pair to high impedance |
| stop_able | input | NUM_OUT | Per-pair stop permission, 1 lets the stop pin halt the pair |
| park_hiz | input | 1 | Stopped-state mode: 0 parks driven, 1 releases to high impedance |
| dif_t | output | NUM_OUT | True clock of each pair |
| dif_c | output | NUM_OUT | Complement clock of each pair |
| dif_oe | output | NUM_OUT | Drive enable of each pair, 1 = driven |

## Verification
The first stimulus uses fixed settings. These include a stop request with no pair stoppable, which checks that the stop pin alone halts nothing, and an alternating stop-permission mask under both park modes, which separates driven parking from release to high impedance on neighbouring pairs. Partly disabled enable masks combined with a stop request show that the enable overrides the stop path. Long runs of random enable, permission, mode and stop-pin changes every few cycles test the three-cycle latency against a delayed reference. A mid-run reset then confirms that pairs return to high impedance and wait out the synchronizer before they drive again.

// File: rtl/diffclk_gate_pkg.sv
package diffclk_gate_pkg;

  // A pair toggles when enabled and not halted by a permitted stop.
  function automatic logic pair_runs(input logic en, input logic stop_act,
                                     input logic able);
    return en & ~(stop_act & able);
  endfunction

  // A pair is driven when enabled, unless halted into high impedance.
  function automatic logic pair_drives(input logic en, input logic stop_act,
                                       input logic able, input logic hiz);
    return en & ~(stop_act & able & hiz);
  endfunction

endpackage

// File: rtl/diffclk_sync.sv
module diffclk_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [STAGES-1:0][W-1:0] chain;

  // Capture on the falling edge so that downstream gating moves while low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/diffclk_gate_cell.sv
module diffclk_gate_cell
  import diffclk_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic able_s,
  input  logic stop_s,
  input  logic hiz_s,
  output logic run_q,
  output logic oe_q
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      run_q <= pair_runs(en_s, stop_s, able_s);
      oe_q  <= pair_drives(en_s, stop_s, able_s, hiz_s);
    end
  end

  AST_FREE_RUN_KEEPS_GOING: assert property (@(negedge clk) disable iff (!rst_n)
    (en_s && !able_s) |=> (run_q && oe_q)) else $error("free-run pair halted"); // R2

  AST_DRIVEN_PARK: assert property (@(negedge clk) disable iff (!rst_n)
    (en_s && stop_s && able_s && !hiz_s) |=> (oe_q && !run_q)) else $error("driven park wrong"); // R3

  AST_HIZ_PARK: assert property (@(negedge clk) disable iff (!rst_n)
    (en_s && stop_s && able_s && hiz_s) |=> (!oe_q && !run_q)) else $error("hiz park wrong"); // R4

  AST_DISABLED_RELEASED: assert property (@(negedge clk) disable iff (!rst_n)
    !en_s |=> (!oe_q && !run_q)) else $error("disabled pair driven"); // R5

  always @(run_q) begin
    if (rst_n) begin
      AST_GATE_MOVES_LOW: assert (clk == 1'b0) else $error("gate moved while high"); // R7
    end
  end

endmodule

// File: rtl/diffclk_pad.sv
module diffclk_pad (
  input  logic clk,
  input  logic run,
  input  logic oe,
  output logic ck_t,
  output logic ck_c,
  output logic ck_oe
);

  logic pulse;

  assign pulse = clk & run;
  assign ck_t  = pulse;
  assign ck_c  = ~pulse;
  assign ck_oe = oe;

endmodule

// File: rtl/diffclk_gate.sv
module diffclk_gate #(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               pll_clk,
  input  logic               rst_n,
  input  logic               stop_pin_n,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic [NUM_OUT-1:0] stop_able,
  input  logic               park_hiz,
  output logic [NUM_OUT-1:0] dif_t,
  output logic [NUM_OUT-1:0] dif_c,
  output logic [NUM_OUT-1:0] dif_oe
);

  localparam int BUS_W    = 2 * NUM_OUT + 2;
  localparam int EN_LO    = 0;
  localparam int ABLE_LO  = NUM_OUT;
  localparam int HIZ_BIT  = 2 * NUM_OUT;
  localparam int STOP_BIT = 2 * NUM_OUT + 1;
  // Reset: stop pin idle high, mode driven, no permission, no enable.
  localparam logic [BUS_W-1:0] SYNC_RST =
    {1'b1, 1'b0, {NUM_OUT{1'b0}}, {NUM_OUT{1'b0}}};

  logic [BUS_W-1:0]   ctl_async;
  logic [BUS_W-1:0]   ctl_sync;
  logic [NUM_OUT-1:0] en_s;
  logic [NUM_OUT-1:0] able_s;
  logic               hiz_s;
  logic               stop_s;
  logic [NUM_OUT-1:0] run_q;
  logic [NUM_OUT-1:0] oe_q;

  assign ctl_async = {stop_pin_n, park_hiz, stop_able, out_en};

  diffclk_sync #(
    .W       (BUS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (pll_clk),
    .rst_n   (rst_n),
    .d_async (ctl_async),
    .d_sync  (ctl_sync)
  );

  assign en_s   = ctl_sync[EN_LO   +: NUM_OUT];
  assign able_s = ctl_sync[ABLE_LO +: NUM_OUT];
  assign hiz_s  = ctl_sync[HIZ_BIT];
  assign stop_s = ~ctl_sync[STOP_BIT];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
    diffclk_gate_cell u_cell (
      .clk    (pll_clk),
      .rst_n  (rst_n),
      .en_s   (en_s[i]),
      .able_s (able_s[i]),
      .stop_s (stop_s),
      .hiz_s  (hiz_s),
      .run_q  (run_q[i]),
      .oe_q   (oe_q[i])
    );

    diffclk_pad u_pad (
      .clk   (pll_clk),
      .run   (run_q[i]),
      .oe    (oe_q[i]),
      .ck_t  (dif_t[i]),
      .ck_c  (dif_c[i]),
      .ck_oe (dif_oe[i])
    );
  end

endmodule

// File: tb/diffclk_gate_tb_top.sv
module diffclk_gate_tb_top;
  localparam int N    = 4;
  localparam int MAXC = 1024;
  localparam int LAT  = 3;

  logic         pll_clk = 1'b0;
  logic         rst_n;
  logic         stop_pin_n;
  logic         park_hiz;
  logic [N-1:0] out_en;
  logic [N-1:0] stop_able;
  logic [N-1:0] dif_t, dif_c, dif_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  bit           h_rst  [MAXC];
  bit           h_stop [MAXC];
  bit           h_hiz  [MAXC];
  logic [N-1:0] h_en   [MAXC];
  logic [N-1:0] h_able [MAXC];

  always #4 pll_clk = ~pll_clk;  // 125 MHz

  diffclk_gate #(.NUM_OUT(N), .SYNC_STAGES(2)) dut_i (
    .pll_clk    (pll_clk),
    .rst_n      (rst_n),
    .stop_pin_n (stop_pin_n),
    .out_en     (out_en),
    .stop_able  (stop_able),
    .park_hiz   (park_hiz),
    .dif_t      (dif_t),
    .dif_c      (dif_c),
    .dif_oe     (dif_oe)
  );

  task automatic check_one(input string tag, input int i, input logic [2:0] act,
                           input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d pair %0d t/c/oe actual %b expected %b", tag, cyc, i, act, exp);
    end
  endtask

  // High phase of cycle k shows the inputs of cycle k-LAT, unless reset intervened.
  task automatic check_high();
    bit normal;
    normal = (cyc >= LAT);
    for (int d = 1; d <= LAT; d++) if (cyc - d >= 0 && !h_rst[cyc-d]) normal = 0;
    for (int i = 0; i < N; i++) begin
      logic [2:0] exp;
      string tag;
      if (!normal) begin
        exp = 3'b010; tag = "R1";
      end else begin
        int j;
        j = cyc - LAT;
        if (!h_en[j][i]) begin
          exp = 3'b010; tag = "R5";
        end else if (h_stop[j] && h_able[j][i]) begin
          if (h_hiz[j]) begin exp = 3'b010; tag = "R4"; end
          else          begin exp = 3'b011; tag = "R3"; end
        end else begin
          exp = 3'b101;
          tag = h_stop[j] ? "R2" : "R6/R8";
        end
      end
      check_one(tag, i, {dif_t[i], dif_c[i], dif_oe[i]}, exp);
    end
  endtask

  task automatic check_low();
    for (int i = 0; i < N; i++)
      check_one("R7", i, {dif_t[i], dif_c[i], 1'b0}, 3'b010);
  endtask

  task automatic step(input bit rn, input bit sn, input bit hz,
                      input logic [N-1:0] e, input logic [N-1:0] a);
    @(posedge pll_clk);
    #1 check_high();
    #1;
    rst_n = rn; stop_pin_n = sn; park_hiz = hz; out_en = e; stop_able = a;
    if (cyc < MAXC) begin
      h_rst[cyc] = rn; h_stop[cyc] = !sn; h_hiz[cyc] = hz;
      h_en[cyc] = e; h_able[cyc] = a;
    end
    #3 check_low();
    cyc++;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; stop_pin_n = 1'b1; park_hiz = 1'b0;
    out_en = '1; stop_able = '0;
    // R1: reset held, then released with all enabled
    for (int k = 0; k < 5; k++)  step(0, 1, 0, 4'b1111, 4'b0000);
    for (int k = 0; k < 10; k++) step(1, 1, 0, 4'b1111, 4'b0000);
    // R2: stop request with no pair stoppable
    for (int k = 0; k < 8; k++)  step(1, 0, 0, 4'b1111, 4'b0000);
    // R3: alternating permission, driven park
    for (int k = 0; k < 8; k++)  step(1, 0, 0, 4'b1111, 4'b0101);
    for (int k = 0; k < 6; k++)  step(1, 1, 0, 4'b1111, 4'b0101);
    // R4: other permission mask, high-impedance park
    for (int k = 0; k < 8; k++)  step(1, 0, 1, 4'b1111, 4'b1010);
    // R5: disabled pairs with and without stop
    for (int k = 0; k < 6; k++)  step(1, 0, 1, 4'b0110, 4'b1111);
    for (int k = 0; k < 6; k++)  step(1, 1, 0, 4'b0011, 4'b0000);
    // R6: single-cycle pulses on the stop pin
    for (int k = 0; k < 10; k++) step(1, k[0], 0, 4'b1111, 4'b1111);
    // random traffic
    begin
      bit sn = 1, hz = 0;
      logic [N-1:0] e = '1, a = '0;
      for (int k = 0; k < 300; k++) begin
        if ($urandom_range(0, 3) == 0) sn = ~sn;
        if ($urandom_range(0, 19) == 0) hz = ~hz;
        if ($urandom_range(0, 7) == 0) e = N'($urandom) | N'($urandom);
        if ($urandom_range(0, 5) == 0) a = N'($urandom);
        step(1, sn, hz, e, a);
      end
      // R1: reset again mid-run
      for (int k = 0; k < 3; k++) step(0, sn, hz, e, a);
      for (int k = 0; k < 60; k++) begin
        if ($urandom_range(0, 3) == 0) sn = ~sn;
        if ($urandom_range(0, 9) == 0) hz = ~hz;
        step(1, sn, hz, e, N'($urandom));
      end
    end
    step(1, 1, 0, 4'b1111, 4'b0000);
    finish_run();
  end

endmodule